// File: doc/BRIEF.md
# Clocked Serial Master Receiver

This block is the receive half of a three-wire synchronous serial master. A start strobe launches one frame: the block drives the serial clock on `sck_o`, takes one data bit from `si_i` per clock period, and at the end places the assembled word in a data register. It also raises a single-cycle transfer-end interrupt. A frame is 7 or 8 bits long. Bit order, clock polarity and data phase can each be chosen for every frame. The bit rate comes from a power-of-two prescaler followed by a 7-bit divider.

The configuration pins are captured when a frame starts, so they may change freely while a frame runs. The host marks a word as consumed with a read strobe. If a frame completes while the previous word is still unconsumed, the block sets a sticky overrun flag, which the host clears with a write-one strobe.

Top module: `ser_rx_master`

## Requirements
- R1: Under reset and in the first cycle after it, `busy_o`, `done_irq_o`, `ovf_o` and `sck_o` are 0 and `rx_data_o` is 0.
- R2: A start strobe taken while idle raises `busy_o` in the next cycle. `busy_o` then stays high for exactly 2·B·H cycles, where B is the frame length and H = (max(N,1)+1)·2^min(E,11). N is `div_n_i` and E is `presc_exp_i`, both captured at start.
- R3: While idle, `sck_o` follows `clk_inv_i` with one cycle of delay. During a frame, the level in half-period h is pol XOR (h odd) when the phase bit is 1, and pol XOR (h even) when it is 0. So with phase 0, `sck_o` leaves idle at the first edge, and with phase 1 it stays idle for the first half-period. After the last half-period it returns to the idle level pol.
- R4: `si_i` is sampled at the clock edge that opens each even half-period, and the start edge counts as the first of these. A slave that changes its data on entry to each odd half-period is therefore received without error.
- R5: `lsb_first_i` = 0 takes the most significant frame bit first. `lsb_first_i` = 1 takes bit 0 first.
- R6: `frame8_i` = 1 selects an 8-bit frame. `frame8_i` = 0 selects a 7-bit frame, which lands in bits 6:0 of `rx_data_o` with bit 7 read as 0.
- R7: `done_irq_o` is high for exactly one cycle per frame, in the cycle where `busy_o` has just fallen. `rx_data_o` changes only in that cycle.
- R8: `ovf_o` is set when a frame completes while the previous word has not been acknowledged by `rd_ack_i`. An acknowledge in the completion cycle counts. The new word overwrites the data anyway. `ovf_o` stays set until `ovf_clr_i`, and a set in the same cycle wins over the clear.
- R9: A start strobe while `busy_o` is high is ignored and does not change the frame timing.
- R10: A divider value of 0 acts as 1, giving a fastest clock of fCLK/4. A prescaler exponent above 11 acts as 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| frame8_i | input | 1 | 1: 8-bit frame, 0: 7-bit frame |
| lsb_first_i | input | 1 | 1: least significant bit first |
| clk_inv_i | input | 1 | Serial clock polarity (idle level) |
| early_phase_i | input | 1 | Data phase: 1 samples half a period before the clock toggles |
| presc_exp_i | input | 4 | Prescaler exponent E |
| div_n_i | input | 7 | Divider value N |
| si_i | input | 1 | Serial data in |
| rd_ack_i | input | 1 | Host has read the data register |
| ovf_clr_i | input | 1 | Write-one clear of the overrun flag |
| sck_o | output | 1 | Serial clock out |
| busy_o | output | 1 | Frame in progress |
| rx_data_o | output | 8 | Received word |
| done_irq_o | output | 1 | Transfer-end pulse |
| ovf_o | output | 1 | Sticky overrun flag |

## Verification
A slip in the half-period counter or the prescaler shows up at once as a wrong `sck_o` level, at the first half-period boundary that misses the reference model. The model compares every cycle, so the error is reported within one half-period. A wrong half-period index or a wrong sampling condition shifts the captured bits, which appears as a wrong `rx_data_o` on the transfer-end pulse. An error in the pending-read state appears as `ovf_o` disagreeing with the model on the completion cycle of the second frame.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  localparam int unsigned EXP_MAX = 11;

  typedef struct packed {
    logic frame_full;
    logic lsb_first;
    logic pol;
    logic pha;
  } rx_cfg_t;
endpackage

// File: rtl/ser_rx_baud.sv
module ser_rx_baud #(
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned EXP_MAX = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_end_o
);
  localparam int unsigned PRE_W = EXP_MAX;

  logic [EXP_W-1:0] exp_q, exp_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] dcnt_q, dcnt_n;
  logic [PRE_W-1:0] pcnt_q, pcnt_n;
  logic [PRE_W-1:0] pmask;
  logic [EXP_W-1:0] exp_clamped;
  logic [DIV_W-1:0] div_clamped;
  logic             pre_end;

  assign exp_clamped = (exp_i > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_i;
  assign div_clamped = (div_i == '0) ? DIV_W'(1) : div_i;
  assign pmask       = ~({PRE_W{1'b1}} << exp_q);
  assign pre_end     = (pcnt_q == pmask);

  always_comb begin
    exp_n      = exp_q;
    div_n      = div_q;
    dcnt_n     = dcnt_q;
    pcnt_n     = pcnt_q;
    half_end_o = 1'b0;
    if (load_i) begin
      exp_n  = exp_clamped;
      div_n  = div_clamped;
      dcnt_n = div_clamped;
      pcnt_n = '0;
    end else if (run_i) begin
      if (pre_end) begin
        pcnt_n = '0;
        if (dcnt_q == '0) begin
          dcnt_n     = div_q;
          half_end_o = 1'b1;
        end else begin
          dcnt_n = dcnt_q - 1'b1;
        end
      end else begin
        pcnt_n = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= '0;
      div_q  <= '0;
      dcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      exp_q  <= exp_n;
      div_q  <= div_n;
      dcnt_q <= dcnt_n;
      pcnt_q <= pcnt_n;
    end
  end
endmodule

// File: rtl/ser_rx_shift.sv
module ser_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic              si_i,
  input  logic              lsb_first_i,
  input  logic              full_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q, sh_n, base;

  always_comb begin
    base = clr_i ? '0 : sh_q;
    sh_n = base;
    if (smp_i) begin
      if (lsb_first_i) sh_n = {si_i, base[DATA_W-1:1]};
      else             sh_n = {base[DATA_W-2:0], si_i};
    end
  end

  always_comb begin
    if (full_i)           word_o = sh_q;
    else if (lsb_first_i) word_o = {1'b0, sh_q[DATA_W-1:1]};
    else                  word_o = {1'b0, sh_q[DATA_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end
endmodule

// File: rtl/ser_rx_status.sv
module ser_rx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              rd_ack_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] data_q, data_n;
  logic              irq_q, unread_q, unread_n, ovf_q, ovf_n, still_unread;

  always_comb begin
    still_unread = unread_q & ~rd_ack_i;
    data_n       = done_i ? word_i : data_q;
    unread_n     = done_i | still_unread;
    ovf_n        = (ovf_q & ~ovf_clr_i) | (done_i & still_unread);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      irq_q    <= 1'b0;
      unread_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      data_q   <= data_n;
      irq_q    <= done_i;
      unread_q <= unread_n;
      ovf_q    <= ovf_n;
    end
  end

  assign data_o = data_q;
  assign irq_o  = irq_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/ser_rx_master.sv
module ser_rx_master
  import ser_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EXP_W  = 4,
  parameter int unsigned DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              frame8_i,
  input  logic              lsb_first_i,
  input  logic              clk_inv_i,
  input  logic              early_phase_i,
  input  logic [EXP_W-1:0]  presc_exp_i,
  input  logic [DIV_W-1:0]  div_n_i,
  input  logic              si_i,
  input  logic              rd_ack_i,
  input  logic              ovf_clr_i,
  output logic              sck_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_irq_o,
  output logic              ovf_o
);
  localparam int unsigned HALF_W    = $clog2(2 * DATA_W);
  localparam int unsigned LAST_FULL = 2 * DATA_W - 1;
  localparam int unsigned LAST_SHRT = 2 * DATA_W - 3;

  rx_cfg_t           cfg_q, cfg_n;
  logic              busy_q, busy_n;
  logic              sck_q, sck_n;
  logic [HALF_W-1:0] half_q, half_n, last_half;
  logic              start_go, half_end, smp, done;
  logic              lsb_sel, full_sel;
  logic [DATA_W-1:0] word;

  assign start_go  = start_i & ~busy_q;
  assign last_half = cfg_q.frame_full ? HALF_W'(LAST_FULL) : HALF_W'(LAST_SHRT);
  assign lsb_sel   = start_go ? lsb_first_i : cfg_q.lsb_first;
  assign full_sel  = cfg_q.frame_full;

  function automatic logic sck_level(input rx_cfg_t c, input logic h_odd);
    return c.pol ^ (c.pha ? h_odd : ~h_odd);
  endfunction

  always_comb begin
    cfg_n  = cfg_q;
    busy_n = busy_q;
    half_n = half_q;
    sck_n  = sck_q;
    smp    = 1'b0;
    done   = 1'b0;
    if (start_go) begin
      cfg_n.frame_full = frame8_i;
      cfg_n.lsb_first  = lsb_first_i;
      cfg_n.pol        = clk_inv_i;
      cfg_n.pha        = early_phase_i;
      busy_n           = 1'b1;
      half_n           = '0;
      sck_n            = clk_inv_i ^ ~early_phase_i;
      smp              = 1'b1;
    end else if (busy_q) begin
      if (half_end) begin
        if (half_q == last_half) begin
          busy_n = 1'b0;
          sck_n  = cfg_q.pol;
          done   = 1'b1;
        end else begin
          half_n = half_q + 1'b1;
          sck_n  = sck_level(cfg_q, ~half_q[0]);
          smp    = half_q[0];
        end
      end
    end else begin
      sck_n = clk_inv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      half_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      busy_q <= busy_n;
      half_q <= half_n;
      sck_q  <= sck_n;
    end
  end

  ser_rx_baud #(
    .EXP_W  (EXP_W),
    .DIV_W  (DIV_W),
    .EXP_MAX(EXP_MAX)
  ) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start_go),
    .run_i     (busy_q),
    .exp_i     (presc_exp_i),
    .div_i     (div_n_i),
    .half_end_o(half_end)
  );

  ser_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_go),
    .smp_i      (smp),
    .si_i       (si_i),
    .lsb_first_i(lsb_sel),
    .full_i     (full_sel),
    .word_o     (word)
  );

  ser_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_i   (done),
    .word_i   (word),
    .rd_ack_i (rd_ack_i),
    .ovf_clr_i(ovf_clr_i),
    .data_o   (rx_data_o),
    .irq_o    (done_irq_o),
    .ovf_o    (ovf_o)
  );

  assign sck_o  = sck_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/ser_rx_master_chk.sv
module ser_rx_master_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              clk_inv_i,
  input logic              ovf_clr_i,
  input logic              sck_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              done_irq_o,
  input logic              ovf_o,
  input logic              frame_full
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  p_idle_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && $past(!busy_o) |-> sck_o == $past(clk_inv_i));

  p_short_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o && !frame_full |-> !rx_data_o[DATA_W-1]);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |=> !done_irq_o);

  p_irq_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |-> $fell(busy_o));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_irq_o |-> $stable(rx_data_o));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> done_irq_o);
endmodule

bind ser_rx_master ser_rx_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .clk_inv_i (clk_inv_i),
  .ovf_clr_i (ovf_clr_i),
  .sck_o     (sck_o),
  .busy_o    (busy_o),
  .rx_data_o (rx_data_o),
  .done_irq_o(done_irq_o),
  .ovf_o     (ovf_o),
  .frame_full(cfg_q.frame_full)
);

// File: tb/ser_rx_master_bench.sv
module ser_rx_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 180000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, frame8_i, lsb_first_i, clk_inv_i, early_phase_i;
  logic [3:0] presc_exp_i;
  logic [6:0] div_n_i;
  logic       si_i, rd_ack_i, ovf_clr_i;
  logic       sck_o, busy_o, done_irq_o, ovf_o;
  logic [7:0] rx_data_o;

  int n_total = 0;
  int n_fail  = 0;

  // slave model
  logic [7:0] s_val = 8'h00;
  int         s_bits = 8;
  bit         s_lsb = 1'b0, s_pol = 1'b0, s_pha = 1'b0, s_active = 1'b0;
  int         s_edges = 0, s_base = 0, s_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_rx_master u_ser_rx_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame8_i(frame8_i),
    .lsb_first_i(lsb_first_i), .clk_inv_i(clk_inv_i), .early_phase_i(early_phase_i),
    .presc_exp_i(presc_exp_i), .div_n_i(div_n_i), .si_i(si_i), .rd_ack_i(rd_ack_i),
    .ovf_clr_i(ovf_clr_i), .sck_o(sck_o), .busy_o(busy_o), .rx_data_o(rx_data_o),
    .done_irq_o(done_irq_o), .ovf_o(ovf_o)
  );

  // R4: slave moves to its next bit on the edge that opens an odd half-period
  always @(sck_o) begin
    if (s_active && sck_o == (s_pha ? ~s_pol : s_pol)) s_edges++;
  end
  assign s_idx = s_edges - s_base;
  assign si_i  = (s_idx >= s_bits) ? 1'b0 :
                 (s_lsb ? s_val[s_idx] : s_val[s_bits - 1 - s_idx]);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced once per rising edge
  bit         m_busy, m_sck, m_irq, m_ovf, m_unread, m_pol, m_pha, m_full, m_done;
  int         m_el, m_h, m_b, m_half;
  logic [7:0] m_data, m_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sck = 0; m_irq = 0; m_ovf = 0; m_unread = 0;
      m_data = 8'h00; m_el = 0; m_h = 1; m_b = 8;
      m_pol = 0; m_pha = 0; m_full = 0; m_val = 8'h00;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_el++;
        if (m_el == 2 * m_b * m_h) begin
          m_busy = 0; m_done = 1; m_sck = m_pol;
        end else begin
          m_half = m_el / m_h;
          m_sck  = m_pol ^ (m_pha ? (m_half % 2 == 1) : (m_half % 2 == 0));
        end
      end else if (start_i) begin
        m_full = frame8_i; m_pol = clk_inv_i; m_pha = early_phase_i;
        m_b    = frame8_i ? 8 : 7;
        m_h    = (((div_n_i == 0) ? 1 : int'(div_n_i)) + 1)
                 << ((presc_exp_i > 11) ? 11 : int'(presc_exp_i));
        m_val  = s_val;
        m_busy = 1; m_el = 0;
        m_sck  = clk_inv_i ^ !early_phase_i;
      end else begin
        m_sck = clk_inv_i;
      end
      if (rd_ack_i) m_unread = 0;
      if (ovf_clr_i) m_ovf = 0;
      if (m_done) begin
        if (m_unread) m_ovf = 1;
        m_unread = 1;
        m_data   = m_full ? m_val : (m_val & 8'h7F);
      end
      m_irq = m_done;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == m_busy,     "R2", "busy_o",     busy_o,     m_busy);
      chk(sck_o == m_sck,       "R3", "sck_o",      sck_o,      m_sck);
      chk(done_irq_o == m_irq,  "R7", "done_irq_o", done_irq_o, m_irq);
      chk(rx_data_o == m_data,  "R5", "rx_data_o",  rx_data_o,  m_data);
      chk(ovf_o == m_ovf,       "R8", "ovf_o",      ovf_o,      m_ovf);
    end
  end

  task automatic run_frame(input bit full, input bit lsb, input bit pol, input bit pha,
                           input int e, input int n, input logic [7:0] val,
                           input bit ack, input bit poke);
    int cnt, hh, bb;
    logic [7:0] expv;
    @(negedge clk);
    frame8_i = full; lsb_first_i = lsb; clk_inv_i = pol; early_phase_i = pha;
    presc_exp_i = 4'(e); div_n_i = 7'(n);
    @(negedge clk);
    s_val = val; s_bits = full ? 8 : 7; s_lsb = lsb; s_pol = pol; s_pha = pha;
    s_base = s_edges; s_active = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (!done_irq_o) begin
      if (busy_o) cnt++;
      start_i = (poke && cnt == 5) ? 1'b1 : 1'b0;  // R9 stimulus
      @(negedge clk);
    end
    start_i = 1'b0;
    bb   = full ? 8 : 7;
    hh   = ((n == 0 ? 1 : n) + 1) << (e > 11 ? 11 : e);
    expv = full ? val : (val & 8'h7F);
    if (e > 11 || n == 0)
      chk(cnt == 2 * bb * hh, "R10", "clamped frame cycles", cnt, 2 * bb * hh);
    else if (poke)
      chk(cnt == 2 * bb * hh, "R9", "frame cycles with start while busy", cnt, 2 * bb * hh);
    else
      chk(cnt == 2 * bb * hh, "R2", "frame cycles", cnt, 2 * bb * hh);
    chk(rx_data_o == expv, lsb ? "R5" : "R4", "received word", rx_data_o, expv);
    if (!full) chk(rx_data_o[7] == 1'b0, "R6", "bit 7 of short frame", rx_data_o[7], 0);
    s_active = 1'b0;
    if (ack) begin
      rd_ack_i = 1'b1;
      @(negedge clk);
      rd_ack_i = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; frame8_i = 1'b1; lsb_first_i = 1'b0;
    clk_inv_i = 1'b0; early_phase_i = 1'b0; presc_exp_i = 4'd0; div_n_i = 7'd1;
    rd_ack_i = 1'b0; ovf_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_irq_o == 0 && ovf_o == 0 && sck_o == 0, "R1",
        "control outputs in reset", {busy_o, done_irq_o, ovf_o, sck_o}, 0);
    chk(rx_data_o == 8'h00, "R1", "data in reset", rx_data_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && ovf_o == 0 && rx_data_o == 0, "R1", "state after reset",
        {busy_o, ovf_o, rx_data_o}, 0);

    // R3 R4 R5 R6: all phase/polarity pairs, both orders, both lengths
    run_frame(1, 0, 0, 0, 0, 1, 8'hA5, 1, 0);
    run_frame(1, 1, 1, 0, 1, 2, 8'h3C, 1, 0);
    run_frame(0, 0, 0, 1, 0, 3, 8'hD3, 1, 0);
    run_frame(0, 1, 1, 1, 2, 1, 8'hFF, 1, 0);
    run_frame(1, 1, 0, 1, 1, 1, 8'h6E, 1, 0);
    run_frame(1, 0, 1, 1, 0, 2, 8'h19, 1, 0);
    // R10: divider of zero
    run_frame(1, 0, 0, 1, 0, 0, 8'h81, 1, 0);
    // R9: start strobe inside a frame
    run_frame(1, 0, 1, 0, 1, 3, 8'hC6, 1, 1);
    // R8: overrun when the first word is left unread
    run_frame(1, 0, 0, 0, 0, 1, 8'h12, 0, 0);
    chk(ovf_o == 0, "R8", "no overrun after first unread word", ovf_o, 0);
    run_frame(1, 1, 0, 0, 0, 1, 8'h34, 0, 0);
    chk(ovf_o == 1, "R8", "overrun after second unread word", ovf_o, 1);
    chk(rx_data_o == 8'h34, "R8", "overrun word overwrites", rx_data_o, 8'h34);
    repeat (5) @(negedge clk);
    chk(ovf_o == 1, "R8", "overrun flag held", ovf_o, 1);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    chk(ovf_o == 0, "R8", "overrun flag cleared", ovf_o, 0);
    rd_ack_i = 1'b1;
    @(negedge clk);
    rd_ack_i = 1'b0;
    // R10: exponent above the ceiling, short frame
    run_frame(0, 0, 1, 0, 12, 0, 8'h2B, 1, 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule